// File: doc/BRIEF.md
# Condition Code Evaluator and Skip

This block decides whether a fetched instruction may execute, given the four arithmetic flags held in a 32-bit status word. It accepts either a full-width 32-bit opcode or a narrow 16-bit opcode, selected by a state input. For a wide opcode, every instruction carries a four-bit condition code. For a narrow opcode, only the conditional-branch form carries one. In both cases the same condition decoder is used; only the field it reads differs.

The verdict is registered when a valid strobe is presented. When the condition fails, the block also produces the sequential address that lets the fetch logic step over the instruction. That address is the current PC plus the instruction size. Executing the instruction is left to other logic.

Top module: `cond_gate`

## Requirements
- R1: In wide state (`narrow_mode`=0) the condition code is `opcode[31:28]`. The flags are read from `status_word`: N at bit 31, Z at bit 30, C at bit 29 and V at bit 28.
- R2: Codes 0 to 7 test a single flag, as follows:
  - 0 passes when Z=1, and 1 passes when Z=0.
  - 2 passes when C=1, and 3 passes when C=0.
  - 4 passes when N=1, and 5 passes when N=0.
  - 6 passes when V=1, and 7 passes when V=0.
- R3: Code 8 passes when C=1 and Z=0. Code 9 passes when C=0 or Z=1.
- R4: The signed-comparison codes behave as follows:
  - Code 10 passes when N equals V, and code 11 passes when N differs from V.
  - Code 12 passes when Z=0 and N equals V.
  - Code 13 passes when Z=1 or N differs from V.
- R5: Codes 14 and 15 always pass, whatever the flags.
- R6: In narrow state (`narrow_mode`=1) an opcode is conditional only when `opcode[15:12]` is 0xD. Its condition code is then `opcode[11:8]`, decoded as in R2 to R5. In this state `opcode[31:16]` has no effect.
- R7: In narrow state, any opcode whose `opcode[15:12]` is not 0xD passes, whatever the flags.
- R8: When the condition fails, `res_next_pc` becomes `pc_in` plus 4 in wide state, or `pc_in` plus 2 in narrow state. The sum wraps modulo 2^PC_W.
- R9: The result appears one cycle after `in_valid`:
  - `res_valid` is high for exactly the cycle after each cycle in which `in_valid` is high.
  - `res_pass` and `res_next_pc` change only on a clock edge where `in_valid` is high.
- R10: An instruction that passes leaves `res_next_pc` at its previous value.
- R11: While `rst_n` is low, `res_valid`, `res_pass` and `res_next_pc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: inputs are valid this cycle |
| status_word | input | 32 | Status word holding the N, Z, C and V flags |
| opcode | input | 32 | Instruction; narrow opcodes use bits 15:0 |
| narrow_mode | input | 1 | 1 selects 16-bit instruction state |
| pc_in | input | PC_W | Address of the instruction |
| res_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| res_pass | output | 1 | Instruction may execute |
| res_next_pc | output | PC_W | Skip address, updated on a failed condition |

## Verification
The bench builds the block with the default PC_W of 32.

With that width, the bench walks all sixteen codes against all sixteen flag combinations, in both the wide field and the narrow branch field. The full 32-bit address also lets the skip sum wrap at the top of the address space in both states. The bench further drives non-branch narrow opcodes under every flag setting, and puts a deliberately misleading upper half-word into narrow opcodes.

// File: rtl/cond_gate.sv
module cond_gate #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     status_word,
  input  logic [31:0]     opcode,
  input  logic            narrow_mode,
  input  logic [PC_W-1:0] pc_in,
  output logic            res_valid,
  output logic            res_pass,
  output logic [PC_W-1:0] res_next_pc
);
  localparam logic [PC_W-1:0] WIDE_STEP   = PC_W'(4);
  localparam logic [PC_W-1:0] NARROW_STEP = PC_W'(2);
  localparam logic [3:0]      BRANCH_TAG  = 4'hD;

  logic fn, fz, fc, fv;
  assign {fn, fz, fc, fv} = status_word[31:28];

  logic [3:0] code;
  logic       gated, cond_ok, pass_now;

  assign code   = narrow_mode ? opcode[11:8] : opcode[31:28];
  assign gated  = !narrow_mode || (opcode[15:12] == BRANCH_TAG);

  always_comb begin
    case (code)
      4'h0: cond_ok = fz;
      4'h1: cond_ok = !fz;
      4'h2: cond_ok = fc;
      4'h3: cond_ok = !fc;
      4'h4: cond_ok = fn;
      4'h5: cond_ok = !fn;
      4'h6: cond_ok = fv;
      4'h7: cond_ok = !fv;
      4'h8: cond_ok = fc && !fz;
      4'h9: cond_ok = !fc || fz;
      4'hA: cond_ok = (fn == fv);
      4'hB: cond_ok = (fn != fv);
      4'hC: cond_ok = !fz && (fn == fv);
      4'hD: cond_ok = fz || (fn != fv);
      default: cond_ok = 1'b1;
    endcase
  end

  assign pass_now = !gated || cond_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_pass    <= 1'b0;
      res_next_pc <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_pass <= pass_now;
        if (!pass_now)
          res_next_pc <= pc_in + (narrow_mode ? NARROW_STEP : WIDE_STEP);
      end
    end
  end
endmodule

module cond_gate_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [31:0]     status_word,
  input logic [31:0]     opcode,
  input logic            narrow_mode,
  input logic [PC_W-1:0] pc_in,
  input logic            res_valid,
  input logic            res_pass,
  input logic [PC_W-1:0] res_next_pc
);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
  assert_hold_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_next_pc) && $stable(res_pass));
  assert_always_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !narrow_mode && opcode[31:29] == 3'b111 |=> res_pass);
  assert_narrow_other_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && narrow_mode && opcode[15:12] != 4'hD |=> res_pass);
  assert_eq_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !narrow_mode && opcode[31:28] == 4'h0 |=> res_pass == $past(status_word[30]));
  assert_wide_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !narrow_mode |=> res_pass || res_next_pc == $past(pc_in) + PC_W'(4));
  assert_narrow_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && narrow_mode |=> res_pass || res_next_pc == $past(pc_in) + PC_W'(2));
  assert_pass_keeps_pc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !res_pass || $stable(res_next_pc));
endmodule

bind cond_gate cond_gate_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/cond_gate_test.sv
module cond_gate_test;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [31:0]     status_word = '0;
  logic [31:0]     opcode = '0;
  logic            narrow_mode = 1'b0;
  logic [PC_W-1:0] pc_in = '0;
  logic            res_valid, res_pass;
  logic [PC_W-1:0] res_next_pc;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [PC_W-1:0] exp_pc = '0;

  always #5 clk = ~clk;

  cond_gate #(.PC_W(PC_W)) uut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model(logic [3:0] nzcv, logic [3:0] cc);
    bit n = nzcv[3], z = nzcv[2], c = nzcv[1], v = nzcv[0];
    bit ge = ~(n ^ v);
    unique case (cc)
      0: return z;        1: return ~z;
      2: return c;        3: return ~c;
      4: return n;        5: return ~n;
      6: return v;        7: return ~v;
      8: return c & ~z;   9: return ~c | z;
      10: return ge;      11: return ~ge;
      12: return ~z & ge; 13: return z | ~ge;
      default: return 1'b1;
    endcase
  endfunction

  task automatic issue(logic [31:0] sw, logic [31:0] op, logic nm, logic [PC_W-1:0] pc,
                       bit exp_pass, string req);
    @(negedge clk);
    status_word = sw; opcode = op; narrow_mode = nm; pc_in = pc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (!exp_pass) exp_pc = pc + (nm ? PC_W'(2) : PC_W'(4));
    check({req, " valid"}, 64'(res_valid), 64'(1));
    check({req, " pass"}, 64'(res_pass), 64'(exp_pass));
    check({req, " next_pc"}, 64'(res_next_pc), 64'(exp_pc));
  endtask

  task automatic t_reset();
    check("R11 valid", 64'(res_valid), 64'(0));
    check("R11 pass", 64'(res_pass), 64'(0));
    check("R11 next_pc", 64'(res_next_pc), 64'(0));
  endtask

  task automatic t_wide_codes();
    for (int f = 0; f < 16; f++)
      for (int cc = 0; cc < 16; cc++)
        issue({f[3:0], 28'h0ABCDEF}, {cc[3:0], 28'h1234567}, 1'b0,
              32'h1000 + 32'(cc * 64), model(f[3:0], cc[3:0]),
              cc < 8 ? "R1 R2" : cc < 10 ? "R3" : cc < 14 ? "R4" : "R5");
  endtask

  task automatic t_narrow_branch();
    for (int f = 0; f < 16; f++)
      for (int cc = 0; cc < 16; cc++)
        issue({f[3:0], 28'h0}, {16'h0000, 4'hD, cc[3:0], 8'h5A}, 1'b1,
              32'h2000 + 32'(f * 16), model(f[3:0], cc[3:0]), "R6");
  endtask

  task automatic t_narrow_upper_ignored();
    // upper half looks like a failing wide code; narrow branch EQ with Z=1 passes
    issue(32'h4000_0000, 32'h1000_D011, 1'b1, 32'h3000, 1'b1, "R6 upper");
    // upper half looks like always; narrow NE with Z=1 fails, skip by 2
    issue(32'h4000_0000, 32'hE000_D1FF, 1'b1, 32'h3100, 1'b0, "R6 upper");
  endtask

  task automatic t_narrow_other();
    for (int f = 0; f < 16; f++)
      issue({f[3:0], 28'h0}, {16'h0, 4'(f == 13 ? 14 : f), 4'h1, 8'h00}, 1'b1,
            32'h4000, 1'b1, "R7");
  endtask

  task automatic t_hold();
    issue(32'h0, 32'h0000_0000, 1'b0, 32'h5000, 1'b0, "R8 fail");
    issue(32'h0, 32'hE000_0000, 1'b0, 32'h6000, 1'b1, "R10");
    check("R10 keeps pc", 64'(res_next_pc), 64'(32'h5004));
    @(negedge clk);
    pc_in = 32'h7777; status_word = 32'h0; opcode = 32'h0;
    @(negedge clk);
    check("R9 no strobe valid", 64'(res_valid), 64'(0));
    check("R9 no strobe pass", 64'(res_pass), 64'(1));
    check("R9 no strobe pc", 64'(res_next_pc), 64'(32'h5004));
  endtask

  task automatic t_wrap();
    issue(32'h0, 32'h0000_0000, 1'b0, 32'hFFFF_FFFE, 1'b0, "R8 wide wrap");
    issue(32'h0, 32'h0000_D000, 1'b1, 32'hFFFF_FFFF, 1'b0, "R8 narrow wrap");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_wide_codes();
    t_narrow_branch();
    t_narrow_upper_ignored();
    t_narrow_other();
    t_hold();
    t_wrap();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule